// File: doc/BRIEF.md
# Transmit Clock Loss Monitor with Latched Status

This block watches an external transmit clock with a faster system clock and reports when that clock stops toggling. The transmit clock is brought into the system domain through a two-stage synchronizer. Each synchronized transition restarts a quiet-time counter. When the counter reaches a programmable limit, the block declares a loss of clock. The limit is a count of system cycles, and it is normally set to about three transmit periods. Once the clock toggles again, the loss is withdrawn and a separate "loss cleared" event is raised.

The block also holds an 8-bit latched status register. Each bit is sticky and is cleared only by a host write-one-to-clear. Pulses from the elastic store and from the framing counters set their bits. The loss detector sets the two clock bits. A live loss-of-clock pin follows the condition itself, independent of the status register, and an enable input gates it. An active-low interrupt stays asserted while any status bit that the mask enables is set.

Top module: `txclk_loss_monitor`

## Requirements
- R1: After reset, `status` is 0x00, `irq_n` is 1 and `los_pin` is 0.
- R2: Loss is declared once `loss_limit` system cycles pass with no synchronized transmit clock transition. Status bit 0 then sets, and `los_pin` goes high if `los_pin_en` is 1. While the clock keeps toggling with a period well under the limit, no loss is declared.
- R3: When a transition is seen during a loss, the condition ends, `los_pin` drops, and status bit 1 (loss cleared) sets.
- R4: A host write with `host_clr_we`=1 clears every status bit whose `host_clr_data` bit is 1. Clearing bit 0 while the loss persists leaves `los_pin` high.
- R5: `los_pin` is low whenever `los_pin_en` is 0, even during a loss.
- R6: `irq_n` is 0 exactly when some bit is 1 in both `status` and `irq_mask` (a mask bit of 1 enables that bit). It returns to 1 only when no enabled set bit remains.
- R7: `ev_es_full` sets bit 7 and bit 5 (slip). `ev_es_empty` sets bit 6 and bit 5.
- R8: `ev_sf72` sets bit 4, `ev_align` sets bit 3, and `ev_mframe` sets bit 2.
- R9: If an event and a host clear hit the same bit in the same cycle, the bit ends set.
- R10: Status bits are sticky. A bit that receives no clear stays set, and write data bits of 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk_in | input | 1 | Monitored transmit clock (asynchronous) |
| loss_limit | input | CNT_W | Quiet system cycles before loss is declared |
| los_pin_en | input | 1 | Enables the live loss-of-clock pin |
| ev_es_full | input | 1 | Elastic store full, frame deleted |
| ev_es_empty | input | 1 | Elastic store empty, frame repeated |
| ev_sf72 | input | 1 | 72-frame superframe boundary |
| ev_align | input | 1 | Alignment frame event |
| ev_mframe | input | 1 | Multiframe boundary |
| host_clr_we | input | 1 | Host clear strobe |
| host_clr_data | input | 8 | Write-one-to-clear bit pattern |
| irq_mask | input | 8 | Interrupt enable per status bit |
| status | output | 8 | Latched status bits |
| los_pin | output | 1 | Live loss-of-clock condition |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench keeps the default counter width of 16 bits and drives `loss_limit` with 12. It runs the transmit clock at a period of four system cycles, so the limit equals three transmit periods. With these values, a loss can be declared, cleared and recovered within a few dozen cycles. They also leave a clear margin between the "not yet lost" sample and the "lost" sample after the clock stops. The status vectors cover the full/empty slip overlap, same-cycle set and clear, and interrupt release as the mask changes.

// File: rtl/tcmon_pkg.sv
package tcmon_pkg;
  localparam int ST_W        = 8;
  localparam int BIT_LOSS    = 0;
  localparam int BIT_LOSSCLR = 1;
  localparam int BIT_MFRAME  = 2;
  localparam int BIT_ALIGN   = 3;
  localparam int BIT_SF72    = 4;
  localparam int BIT_SLIP    = 5;
  localparam int BIT_EMPTY   = 6;
  localparam int BIT_FULL    = 7;

  typedef struct packed {
    logic es_full;
    logic es_empty;
    logic sf72;
    logic align;
    logic mframe;
    logic loss_set;
    logic loss_clr;
  } tcm_events_t;

  // Map event pulses onto the status bit positions.
  function automatic logic [ST_W-1:0] tcm_set_vector(input tcm_events_t ev);
    logic [ST_W-1:0] v;
    v = '0;
    v[BIT_FULL]    = ev.es_full;
    v[BIT_EMPTY]   = ev.es_empty;
    v[BIT_SLIP]    = ev.es_full | ev.es_empty;
    v[BIT_SF72]    = ev.sf72;
    v[BIT_ALIGN]   = ev.align;
    v[BIT_MFRAME]  = ev.mframe;
    v[BIT_LOSSCLR] = ev.loss_clr;
    v[BIT_LOSS]    = ev.loss_set;
    return v;
  endfunction

  // True when one more quiet cycle reaches the limit.
  function automatic logic tcm_limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return ({1'b0, cnt} + 33'd1) >= {1'b0, lim};
  endfunction
endpackage

// File: rtl/tcmon_sync.sv
module tcmon_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/tcmon_loss_det.sv
module tcmon_loss_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             lost_o,
  output logic             loss_set_o,
  output logic             loss_clr_o
);
  import tcmon_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             lost_q;
  logic             hit_w;

  assign hit_w      = tcm_limit_hit(32'(cnt_q), 32'(limit_i));
  assign loss_set_o = !edge_i && !lost_q && hit_w;
  assign loss_clr_o = edge_i && lost_q;
  assign lost_o     = lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
      if (loss_set_o) lost_q <= 1'b1;
    end
  end

  // R2: a seen transition always withdraws the loss
  p_edge_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !lost_q);

  // R2: loss only starts in a quiet cycle
  p_rise_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(!edge_i));

  // R3: loss ends only on a transition
  p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_q) |-> $past(edge_i));
endmodule

// File: rtl/tcmon_status.sv
module tcmon_status (
  input  logic                      clk,
  input  logic                      rst_n,
  input  tcmon_pkg::tcm_events_t    ev_i,
  input  logic                      clr_we_i,
  input  logic [tcmon_pkg::ST_W-1:0] clr_data_i,
  input  logic [tcmon_pkg::ST_W-1:0] mask_i,
  output logic [tcmon_pkg::ST_W-1:0] status_o,
  output logic                      irq_n_o
);
  import tcmon_pkg::*;

  logic [ST_W-1:0] set_w;
  logic [ST_W-1:0] clr_w;
  logic [ST_W-1:0] st_q;

  assign set_w = tcm_set_vector(ev_i);
  assign clr_w = clr_we_i ? clr_data_i : '0;

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q[i] <= 1'b0;
      else if (set_w[i]) st_q[i] <= 1'b1;
      else if (clr_w[i]) st_q[i] <= 1'b0;
    end
  end

  assign status_o = st_q;
  assign irq_n_o  = ~|(st_q & mask_i);

  // R9 / R7 / R8: every set request is present in the next state
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_w) & ~st_q) == '0));

  // R10: bits without a clear request never drop
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q) & ~$past(clr_w)) & ~st_q) == '0));

  // R7: either elastic store event leaves the slip bit set
  p_slip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i.es_full || ev_i.es_empty) |=> st_q[BIT_SLIP]);
endmodule

// File: rtl/txclk_loss_monitor.sv
module txclk_loss_monitor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_clk_in,
  input  logic [CNT_W-1:0] loss_limit,
  input  logic             los_pin_en,
  input  logic             ev_es_full,
  input  logic             ev_es_empty,
  input  logic             ev_sf72,
  input  logic             ev_align,
  input  logic             ev_mframe,
  input  logic             host_clr_we,
  input  logic [7:0]       host_clr_data,
  input  logic [7:0]       irq_mask,
  output logic [7:0]       status,
  output logic             los_pin,
  output logic             irq_n
);
  import tcmon_pkg::*;

  logic        edge_w;
  logic        lost_w;
  logic        loss_set_w;
  logic        loss_clr_w;
  tcm_events_t ev_w;

  tcmon_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (tx_clk_in),
    .edge_o   (edge_w)
  );

  tcmon_loss_det #(.CNT_W(CNT_W)) u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (edge_w),
    .limit_i    (loss_limit),
    .lost_o     (lost_w),
    .loss_set_o (loss_set_w),
    .loss_clr_o (loss_clr_w)
  );

  always_comb begin
    ev_w.es_full  = ev_es_full;
    ev_w.es_empty = ev_es_empty;
    ev_w.sf72     = ev_sf72;
    ev_w.align    = ev_align;
    ev_w.mframe   = ev_mframe;
    ev_w.loss_set = loss_set_w;
    ev_w.loss_clr = loss_clr_w;
  end

  tcmon_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev_w),
    .clr_we_i   (host_clr_we),
    .clr_data_i (host_clr_data),
    .mask_i     (irq_mask),
    .status_o   (status),
    .irq_n_o    (irq_n)
  );

  assign los_pin = lost_w & los_pin_en;

  // R2: the loss bit is latched on the edge the condition starts
  p_loss_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_w) |-> status[BIT_LOSS]);

  // R3: the cleared bit is latched on the edge the condition ends
  p_clear_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_w) |-> status[BIT_LOSSCLR]);
endmodule

// File: tb/tb_txclk_loss_monitor.sv
`timescale 1ns/1ps
module tb_txclk_loss_monitor;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, tx_clk = 1'b0, tx_run = 1'b1;
  logic [CNT_W-1:0] loss_limit = 16'd12;
  logic los_pin_en = 1'b1;
  logic ev_full = 0, ev_empty = 0, ev_sf72 = 0, ev_align = 0, ev_mf = 0;
  logic clr_we = 0;
  logic [7:0] clr_data = 8'h00, mask = 8'h00;
  logic [7:0] status;
  logic los_pin, irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;
  initial forever begin #16; if (tx_run) tx_clk = ~tx_clk; end

  txclk_loss_monitor #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tx_clk_in(tx_clk), .loss_limit(loss_limit),
    .los_pin_en(los_pin_en), .ev_es_full(ev_full), .ev_es_empty(ev_empty),
    .ev_sf72(ev_sf72), .ev_align(ev_align), .ev_mframe(ev_mf),
    .host_clr_we(clr_we), .host_clr_data(clr_data), .irq_mask(mask),
    .status(status), .los_pin(los_pin), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {full,empty,sf72,align,mf, we, wdata, mask, exp status, exp irq_n}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {5'b10000, 1'b0, 8'h00, 8'h00, 8'hA0, 1'b1},  // R7 full -> 7,5
    {5'b00000, 1'b1, 8'h80, 8'h20, 8'h20, 1'b0},  // R4 clear, R6 irq
    {5'b01000, 1'b1, 8'h20, 8'h20, 8'h60, 1'b0},  // R9 set beats clear, R7
    {5'b00100, 1'b1, 8'h60, 8'h10, 8'h10, 1'b0},  // R8 sf72
    {5'b00011, 1'b0, 8'h00, 8'h01, 8'h1C, 1'b1},  // R8 align+mframe
    {5'b00000, 1'b1, 8'h04, 8'h0C, 8'h18, 1'b0},  // R4
    {5'b00000, 1'b1, 8'h00, 8'hFF, 8'h18, 1'b0},  // R10 zero data
    {5'b00001, 1'b1, 8'h18, 8'h18, 8'h04, 1'b1},  // R6 release
    {5'b11000, 1'b1, 8'h04, 8'h04, 8'hE0, 1'b1},  // R7 both
    {5'b00000, 1'b1, 8'hE0, 8'hFF, 8'h00, 1'b1}   // R4 clear all
  };

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 los_pin", {7'd0, los_pin}, 8'h00);
    cycles(20);
    chk("R2 no loss while toggling", status, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {ev_full, ev_empty, ev_sf72, ev_align, ev_mf} = VEC[i][30:26];
      clr_we = VEC[i][25];
      clr_data = VEC[i][24:17];
      mask = VEC[i][16:9];
      cycles(1);
      {ev_full, ev_empty, ev_sf72, ev_align, ev_mf} = 5'b0;
      clr_we = 1'b0;
      clr_data = 8'h00;
      chk($sformatf("R7/R8/R9 vec%0d status", i), status, VEC[i][8:1]);
      chk($sformatf("R6 vec%0d irq_n", i), {7'd0, irq_n}, {7'd0, VEC[i][0]});
    end

    // Loss of clock
    mask = 8'h03;
    tx_run = 1'b0;
    cycles(8);
    chk("R2 not yet lost", {7'd0, los_pin}, 8'h00);
    cycles(12);
    chk("R2 los_pin", {7'd0, los_pin}, 8'h01);
    chk("R2 status", status, 8'h01);
    chk("R6 irq on loss", {7'd0, irq_n}, 8'h00);

    clr_we = 1'b1; clr_data = 8'h01;
    cycles(1);
    clr_we = 1'b0; clr_data = 8'h00;
    chk("R4 bit0 cleared", status, 8'h00);
    chk("R4 pin held", {7'd0, los_pin}, 8'h01);
    chk("R6 irq released", {7'd0, irq_n}, 8'h01);

    los_pin_en = 1'b0;
    cycles(1);
    chk("R5 pin gated", {7'd0, los_pin}, 8'h00);
    los_pin_en = 1'b1;
    cycles(1);
    chk("R5 pin back", {7'd0, los_pin}, 8'h01);

    tx_run = 1'b1;
    cycles(8);
    chk("R3 pin drops", {7'd0, los_pin}, 8'h00);
    chk("R3 cleared bit", status, 8'h02);
    chk("R6 irq on clear", {7'd0, irq_n}, 8'h00);
    cycles(10);
    chk("R10 cleared bit sticky", status, 8'h02);

    clr_we = 1'b1; clr_data = 8'h02;
    cycles(1);
    clr_we = 1'b0; clr_data = 8'h00;
    chk("R4 clear bit1", status, 8'h00);
    chk("R6 idle irq", {7'd0, irq_n}, 8'h01);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule